// File: doc/BRIEF.md
# Cluster Global Control Registers

This block is a memory-mapped register file that sits beside a small cluster of virtual processors. A single-cycle bus reaches it. Each request carries the index of the core that issued it. The global part holds several registers: the block's own relocatable base, a fixed revision, base-and-enable registers for an interrupt controller window and a power controller window, presence status for both controllers, a constant level-2 cache configuration word and an always-zero configuration word.

Every virtual processor owns a small bank that holds a configuration word, an "other" pointer and a reset base. Two windows reach these banks. The local window always lands on the requesting core's own bank. The remote window lands on the bank whose index sits in the requester's "other" pointer. The block drives a 64-bit exception base vector for each core from that core's reset base. It also drives base and enable lines for the two controller windows, its own region base, and a copy of that base shifted right by 4 for every core.

The address map has three windows. The global block is at 0x0000, the local window at 0x2000 and the remote window at 0x4000. In the global block the offsets are: 0x000 configuration, 0x008 own base, 0x010 revision, 0x018 interrupt-controller base, 0x020 power-controller base, 0x028 interrupt-controller status, 0x030 power-controller status, 0x038 level-2 configuration. In each per-core window the offsets are: 0x000 configuration, 0x008 other pointer, 0x010 reset base.

Top module: `cluster_gcr`

## Requirements
- R1: When reset is released, several values hold. Both controller base registers are 0 and both enables are low. The own base equals BASE_RST masked to bits [47:15], and every mirror output equals that base shifted right by 4. Every "other" pointer is 0. Every reset base is 0xBFC00000, so every exception base output is 0xFFFFFFFF_BFC00000.
- R2: Read data is registered and appears on rdata_o in the cycle after the read request. The global configuration word reads 0. The revision reads REV (default 0x800), and a write to the revision has no effect.
- R3: A write to a controller base register stores the data masked to bits [47:15] plus bit 0, but only when that controller is present (HAS_IC, HAS_PC). Otherwise the register stays 0. The region base output is the stored bits [47:15] and the region enable output is stored bit 0.
- R4: Each controller status register reads 1 when that controller is present and 0 when it is absent.
- R5: The level-2 configuration word always reads with only its bypass bit, bit 20, set (0x0010_0000).
- R6: The per-core configuration word reads NUM_VPS-1 through both the local window and the remote window.
- R7: A local-window access targets bank core_id_i. A remote-window access targets the bank whose index is held in bank core_id_i's "other" pointer. This holds for reads and writes of both the pointer and the reset base.
- R8: A write to an "other" pointer takes wdata_i[7:0]. The write is ignored when that value is greater than or equal to NUM_VPS.
- R9: A reset-base write stores wdata_i masked to bits [31:12]. The core's exception base output then becomes the low 32 bits of that value, sign-extended to 64 bits. This applies whether the write comes through the local window or the remote window.
- R10: A write to the own-base register stores wdata_i masked to bits [47:15] and drives it on self_base_o. The same value shifted right by 4 appears on every core's mirror output.
- R11: Reads from unimplemented or unaligned offsets, or from an unused window, return 0. Writes to them change no output and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, valid for one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset within the block |
| wdata_i | input | 64 | Write data |
| core_id_i | input | IDX_W | Index of the requesting core |
| rdata_o | output | 64 | Registered read data |
| self_base_o | output | 64 | Block's own region base |
| ic_base_o | output | 64 | Interrupt controller region base |
| ic_en_o | output | 1 | Interrupt controller region enable |
| pc_base_o | output | 64 | Power controller region base |
| pc_en_o | output | 1 | Power controller region enable |
| base_mirror_o | output | NUM_VPS*64 | Own base >> 4, one copy per core |
| exc_base_o | output | NUM_VPS*64 | Exception base vector for each core |

## Verification
The assertions check on every cycle that each "other" pointer stays below NUM_VPS. They also check that the reset bases, the own base and the interrupt-controller base change only in a cycle that writes them, and that reads of the revision, the level-2 word and unimplemented offsets return their fixed values one cycle later. Only the bench scenarios can show the other behaviours. These include the pointer indirection of the remote window, rejection of out-of-range pointer values, sign extension of the exception base, masking of written bases, and the per-core fan-out of the mirror output.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
  localparam int unsigned DW        = 64;
  localparam int unsigned WIN_SHIFT = 13;
  localparam int unsigned OFF_W     = WIN_SHIFT;
  localparam int unsigned OTHER_FW  = 8;
  localparam int unsigned L2_BYP    = 20;

  localparam logic [DW-1:0] BASE_MASK  = 64'h0000_FFFF_FFFF_8000;
  localparam logic [DW-1:0] CTL_MASK   = BASE_MASK | 64'h1;
  localparam logic [DW-1:0] RBASE_MASK = 64'h0000_0000_FFFF_F000;
  localparam logic [DW-1:0] RBASE_RST  = 64'h0000_0000_BFC0_0000;

  // global block offsets
  localparam logic [OFF_W-1:0] G_CFG  = 13'h000;
  localparam logic [OFF_W-1:0] G_BASE = 13'h008;
  localparam logic [OFF_W-1:0] G_REV  = 13'h010;
  localparam logic [OFF_W-1:0] G_ICB  = 13'h018;
  localparam logic [OFF_W-1:0] G_PCB  = 13'h020;
  localparam logic [OFF_W-1:0] G_ICS  = 13'h028;
  localparam logic [OFF_W-1:0] G_PCS  = 13'h030;
  localparam logic [OFF_W-1:0] G_L2   = 13'h038;
  // per-core window offsets
  localparam logic [OFF_W-1:0] V_CFG   = 13'h000;
  localparam logic [OFF_W-1:0] V_OTHER = 13'h008;
  localparam logic [OFF_W-1:0] V_RBASE = 13'h010;

  typedef enum logic [1:0] {WIN_GLB, WIN_LCL, WIN_OTH, WIN_NONE} win_e;

  typedef enum logic [3:0] {
    RS_NONE, RS_CFG, RS_BASE, RS_REV, RS_ICB, RS_PCB, RS_ICS, RS_PCS, RS_L2,
    RS_VP_CFG, RS_VP_OTHER, RS_VP_RBASE
  } reg_e;
endpackage

// File: rtl/gcr_decode.sv
module gcr_decode
  import gcr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output win_e              win_o,
  output reg_e              sel_o
);
  localparam int unsigned WSEL_W = ADDR_W - WIN_SHIFT;

  logic [WSEL_W-1:0] wsel;
  logic [OFF_W-1:0]  off;

  assign wsel = addr_i[ADDR_W-1:WIN_SHIFT];
  assign off  = addr_i[WIN_SHIFT-1:0];

  always_comb begin
    if (wsel == WSEL_W'(0))      win_o = WIN_GLB;
    else if (wsel == WSEL_W'(1)) win_o = WIN_LCL;
    else if (wsel == WSEL_W'(2)) win_o = WIN_OTH;
    else                         win_o = WIN_NONE;
  end

  always_comb begin
    sel_o = RS_NONE;
    unique case (win_o)
      WIN_GLB: begin
        unique case (off)
          G_CFG:   sel_o = RS_CFG;
          G_BASE:  sel_o = RS_BASE;
          G_REV:   sel_o = RS_REV;
          G_ICB:   sel_o = RS_ICB;
          G_PCB:   sel_o = RS_PCB;
          G_ICS:   sel_o = RS_ICS;
          G_PCS:   sel_o = RS_PCS;
          G_L2:    sel_o = RS_L2;
          default: sel_o = RS_NONE;
        endcase
      end
      WIN_LCL, WIN_OTH: begin
        unique case (off)
          V_CFG:   sel_o = RS_VP_CFG;
          V_OTHER: sel_o = RS_VP_OTHER;
          V_RBASE: sel_o = RS_VP_RBASE;
          default: sel_o = RS_NONE;
        endcase
      end
      default: sel_o = RS_NONE;
    endcase
  end
endmodule

// File: rtl/gcr_global_regs.sv
module gcr_global_regs
  import gcr_pkg::*;
#(
  parameter logic [63:0] BASE_RST = 64'h0000_0000_1FBF_8000,
  parameter bit          HAS_IC   = 1'b1,
  parameter bit          HAS_PC   = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_base_i,
  input  logic          wr_icb_i,
  input  logic          wr_pcb_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] base_q_o,
  output logic [DW-1:0] icb_q_o,
  output logic [DW-1:0] pcb_q_o,
  output logic [DW-1:0] ic_base_o,
  output logic          ic_en_o,
  output logic [DW-1:0] pc_base_o,
  output logic          pc_en_o
);
  logic [DW-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        base_q <= BASE_RST & BASE_MASK;
    else if (wr_base_i) base_q <= wdata_i & BASE_MASK;
  end
  assign base_q_o = base_q;

  generate
    if (HAS_IC) begin : g_ic
      logic [DW-1:0] icb_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       icb_q <= '0;
        else if (wr_icb_i) icb_q <= wdata_i & CTL_MASK;
      end
      assign icb_q_o = icb_q;

      p_icb_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_icb_i |=> $stable(icb_q));
    end else begin : g_no_ic
      assign icb_q_o = '0;
    end

    if (HAS_PC) begin : g_pc
      logic [DW-1:0] pcb_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       pcb_q <= '0;
        else if (wr_pcb_i) pcb_q <= wdata_i & CTL_MASK;
      end
      assign pcb_q_o = pcb_q;
    end else begin : g_no_pc
      assign pcb_q_o = '0;
    end
  endgenerate

  assign ic_base_o = icb_q_o & BASE_MASK;
  assign ic_en_o   = icb_q_o[0];
  assign pc_base_o = pcb_q_o & BASE_MASK;
  assign pc_en_o   = pcb_q_o[0];

  p_base_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_base_i |=> $stable(base_q));
endmodule

// File: rtl/gcr_vp_bank.sv
module gcr_vp_bank
  import gcr_pkg::*;
#(
  parameter int unsigned NUM_VPS = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_other_i,
  input  logic             wr_rbase_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [IDX_W-1:0] other_o,
  output logic [DW-1:0]    rbase_o,
  output logic [DW-1:0]    exc_base_o
);
  logic [IDX_W-1:0] other_q;
  logic [DW-1:0]    rbase_q;
  logic             other_ok;

  assign other_ok = 32'(wdata_i[OTHER_FW-1:0]) < NUM_VPS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      other_q <= '0;
      rbase_q <= RBASE_RST & RBASE_MASK;
    end else begin
      if (wr_other_i && other_ok) other_q <= IDX_W'(wdata_i[OTHER_FW-1:0]);
      if (wr_rbase_i)             rbase_q <= wdata_i & RBASE_MASK;
    end
  end

  assign other_o    = other_q;
  assign rbase_o    = rbase_q;
  assign exc_base_o = {{32{rbase_q[31]}}, rbase_q[31:0]};

  always_comb begin
    if (rst_ni) p_other_bound_r8: assert (32'(other_q) < NUM_VPS);
  end

  p_rbase_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_rbase_i |=> $stable(rbase_q));
endmodule

// File: rtl/cluster_gcr.sv
module cluster_gcr
  import gcr_pkg::*;
#(
  parameter int unsigned NUM_VPS  = 4,
  parameter int unsigned ADDR_W   = 16,
  parameter logic [63:0] REV      = 64'h800,
  parameter logic [63:0] BASE_RST = 64'h0000_0000_1FBF_8000,
  parameter bit          HAS_IC   = 1'b1,
  parameter bit          HAS_PC   = 1'b0,
  localparam int unsigned IDX_W   = (NUM_VPS > 1) ? $clog2(NUM_VPS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [63:0]           wdata_i,
  input  logic [IDX_W-1:0]      core_id_i,
  output logic [63:0]           rdata_o,
  output logic [63:0]           self_base_o,
  output logic [63:0]           ic_base_o,
  output logic                  ic_en_o,
  output logic [63:0]           pc_base_o,
  output logic                  pc_en_o,
  output logic [NUM_VPS*64-1:0] base_mirror_o,
  output logic [NUM_VPS*64-1:0] exc_base_o
);
  win_e win;
  reg_e sel;

  gcr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(addr_i), .win_o(win), .sel_o(sel)
  );

  logic wr, rd;
  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  logic [DW-1:0] base_q, icb_q, pcb_q;

  gcr_global_regs #(.BASE_RST(BASE_RST), .HAS_IC(HAS_IC), .HAS_PC(HAS_PC)) u_glb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_base_i(wr && sel == RS_BASE),
    .wr_icb_i (wr && sel == RS_ICB),
    .wr_pcb_i (wr && sel == RS_PCB),
    .wdata_i(wdata_i),
    .base_q_o(base_q), .icb_q_o(icb_q), .pcb_q_o(pcb_q),
    .ic_base_o(ic_base_o), .ic_en_o(ic_en_o),
    .pc_base_o(pc_base_o), .pc_en_o(pc_en_o)
  );
  assign self_base_o = base_q;

  logic [IDX_W-1:0] other_w [NUM_VPS];
  logic [DW-1:0]    rbase_w [NUM_VPS];
  logic             id_ok;
  logic [IDX_W-1:0] my_other;
  logic [IDX_W-1:0] tgt;
  logic             vp_hit;

  assign id_ok    = 32'(core_id_i) < NUM_VPS;
  assign my_other = id_ok ? other_w[core_id_i] : '0;
  assign tgt      = (win == WIN_LCL) ? core_id_i : my_other;
  assign vp_hit   = id_ok && (win == WIN_LCL || win == WIN_OTH);

  generate
    for (genvar k = 0; k < NUM_VPS; k++) begin : g_vp
      logic hit_k;
      assign hit_k = wr && vp_hit && tgt == IDX_W'(k);

      gcr_vp_bank #(.NUM_VPS(NUM_VPS), .IDX_W(IDX_W)) u_bank (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .wr_other_i(hit_k && sel == RS_VP_OTHER),
        .wr_rbase_i(hit_k && sel == RS_VP_RBASE),
        .wdata_i(wdata_i),
        .other_o(other_w[k]),
        .rbase_o(rbase_w[k]),
        .exc_base_o(exc_base_o[k*64 +: 64])
      );
      assign base_mirror_o[k*64 +: 64] = base_q >> 4;
    end
  endgenerate

  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    unique case (sel)
      RS_BASE:     rd_val = base_q;
      RS_REV:      rd_val = REV;
      RS_ICB:      rd_val = icb_q;
      RS_PCB:      rd_val = pcb_q;
      RS_ICS:      rd_val = DW'(HAS_IC);
      RS_PCS:      rd_val = DW'(HAS_PC);
      RS_L2:       rd_val = DW'(1) << L2_BYP;
      RS_VP_CFG:   rd_val = vp_hit ? DW'(NUM_VPS - 1) : '0;
      RS_VP_OTHER: rd_val = vp_hit ? DW'(other_w[tgt]) : '0;
      RS_VP_RBASE: rd_val = vp_hit ? rbase_w[tgt] : '0;
      default:     rd_val = '0;
    endcase
  end

  logic [DW-1:0] rdata_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd) rdata_q <= rd_val;
  end
  assign rdata_o = rdata_q;

  p_unimpl_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && sel == RS_NONE |=> rdata_o == '0);
  p_rev_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && sel == RS_REV |=> rdata_o == REV);
  p_l2_bypass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && sel == RS_L2 |=> $countones(rdata_o) == 1 && rdata_o[L2_BYP]);
  p_write_keeps_rdata_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

// File: tb/cluster_gcr_test.sv
module cluster_gcr_test;
  localparam int NV = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req = 1'b0, we = 1'b0;
  logic [15:0]     addr = '0;
  logic [63:0]     wdata = '0;
  logic [1:0]      cid = '0;
  logic [63:0]     rdata, self_base, ic_base, pc_base;
  logic            ic_en, pc_en;
  logic [NV*64-1:0] mirror, exc;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  cluster_gcr uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .core_id_i(cid), .rdata_o(rdata), .self_base_o(self_base),
    .ic_base_o(ic_base), .ic_en_o(ic_en), .pc_base_o(pc_base), .pc_en_o(pc_en),
    .base_mirror_o(mirror), .exc_base_o(exc)
  );

  localparam logic [15:0] LCL = 16'h2000, OTH = 16'h4000;

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] id, logic [15:0] a, logic [63:0] d);
    @(negedge clk);
    req = 1; we = 1; cid = id; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(logic [1:0] id, logic [15:0] a, output logic [63:0] d);
    @(negedge clk);
    req = 1; we = 0; cid = id; addr = a;
    @(negedge clk);
    req = 0;
    d = rdata;
  endtask

  task automatic t_reset;
    chk("R1 ic_base", ic_base, 64'h0);
    chk("R1 ic_en", 64'(ic_en), 64'h0);
    chk("R1 pc_en", 64'(pc_en), 64'h0);
    chk("R1 self_base", self_base, 64'h1FBF_8000);
    for (int k = 0; k < NV; k++) begin
      chk("R1 mirror", mirror[k*64 +: 64], 64'h01FB_F800);
      chk("R1 exc", exc[k*64 +: 64], 64'hFFFF_FFFF_BFC0_0000);
    end
  endtask

  task automatic t_global;
    logic [63:0] d;
    rd(0, 16'h0000, d); chk("R2 cfg", d, 64'h0);
    rd(2, 16'h0010, d); chk("R2 rev", d, 64'h800);
    wr(0, 16'h0010, 64'h1234);
    rd(0, 16'h0010, d); chk("R2 rev write ignored", d, 64'h800);
    rd(0, 16'h0028, d); chk("R4 ic status", d, 64'h1);
    rd(0, 16'h0030, d); chk("R4 pc status", d, 64'h0);
    rd(1, 16'h0038, d); chk("R5 l2 bypass", d, 64'h0010_0000);
  endtask

  task automatic t_ctl;
    logic [63:0] d;
    wr(0, 16'h0018, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R3 ic_base_o", ic_base, 64'h0000_FFFF_FFFF_8000);
    chk("R3 ic_en_o", 64'(ic_en), 64'h1);
    rd(0, 16'h0018, d); chk("R3 ic readback", d, 64'h0000_FFFF_FFFF_8001);
    wr(0, 16'h0018, 64'h0000_1234_5678_9ABE);
    chk("R3 ic disabled", 64'(ic_en), 64'h0);
    chk("R3 ic base2", ic_base, 64'h0000_1234_5678_8000);
    wr(0, 16'h0020, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R3 pc absent en", 64'(pc_en), 64'h0);
    chk("R3 pc absent base", pc_base, 64'h0);
    rd(0, 16'h0020, d); chk("R3 pc readback", d, 64'h0);
  endtask

  task automatic t_windows;
    logic [63:0] d;
    rd(0, LCL, d); chk("R6 local cfg", d, 64'd3);
    rd(3, OTH, d); chk("R6 other cfg", d, 64'd3);
    wr(1, LCL + 16'h008, 64'd3);
    rd(1, LCL + 16'h008, d); chk("R7 local other", d, 64'd3);
    wr(1, OTH + 16'h010, 64'h1234_5678);
    chk("R9 exc3 via other", exc[3*64 +: 64], 64'h0000_0000_1234_5000);
    chk("R7 exc1 untouched", exc[1*64 +: 64], 64'hFFFF_FFFF_BFC0_0000);
    rd(3, LCL + 16'h010, d); chk("R7 bank3 rbase", d, 64'h1234_5000);
    rd(1, OTH + 16'h010, d); chk("R7 other rbase read", d, 64'h1234_5000);
    wr(0, LCL + 16'h010, 64'hFFFF_0000_8765_4321);
    chk("R9 exc0 sign ext", exc[0*64 +: 64], 64'hFFFF_FFFF_8765_4000);
    rd(0, LCL + 16'h010, d); chk("R9 rbase masked", d, 64'h8765_4000);
  endtask

  task automatic t_bounds;
    logic [63:0] d;
    wr(1, LCL + 16'h008, 64'd4);
    rd(1, LCL + 16'h008, d); chk("R8 other 4 rejected", d, 64'd3);
    wr(1, LCL + 16'h008, 64'hFF);
    rd(1, LCL + 16'h008, d); chk("R8 other FF rejected", d, 64'd3);
    wr(1, LCL + 16'h008, 64'h102);
    rd(1, LCL + 16'h008, d); chk("R8 low byte used", d, 64'd2);
    wr(2, OTH + 16'h008, 64'd1);
    rd(0, LCL + 16'h008, d); chk("R7 other-window ptr write bank0", d, 64'd1);
    rd(2, LCL + 16'h008, d); chk("R7 bank2 ptr untouched", d, 64'd0);
  endtask

  task automatic t_base;
    logic [63:0] d;
    wr(3, 16'h0008, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R10 self_base", self_base, 64'h0000_FFFF_FFFF_8000);
    for (int k = 0; k < NV; k++)
      chk("R10 mirror", mirror[k*64 +: 64], 64'h0000_0FFF_FFFF_F800);
    rd(0, 16'h0008, d); chk("R10 readback", d, 64'h0000_FFFF_FFFF_8000);
  endtask

  task automatic t_unimpl;
    logic [63:0] d;
    logic [63:0] sb, ib, e0, e3;
    sb = self_base; ib = ic_base; e0 = exc[63:0]; e3 = exc[3*64 +: 64];
    rd(0, 16'h0100, d); chk("R11 unimpl read", d, 64'h0);
    rd(0, 16'h0009, d); chk("R11 unaligned read", d, 64'h0);
    rd(0, 16'h6000, d); chk("R11 unused window", d, 64'h0);
    wr(0, 16'h6010, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(0, 16'h0100, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(0, LCL + 16'h018, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R11 self_base kept", self_base, sb);
    chk("R11 ic_base kept", ic_base, ib);
    chk("R11 exc0 kept", exc[63:0], e0);
    chk("R11 exc3 kept", exc[3*64 +: 64], e3);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_global();
    t_ctl();
    t_windows();
    t_bounds();
    t_base();
    t_unimpl();
    summary();
  end
endmodule